// File: doc/BRIEF.md
# Host Queue-Pair Ring Bridge

This bridge connects the host side of a storage device to its internal message ring. It acts in hardware for the host endpoints. Each endpoint index owns a pair of queues. The downstream queue carries messages from the host toward the ring. The upstream queue holds ring traffic addressed back to that endpoint. The host adds a message to a downstream queue by ringing a doorbell. The bridge sends waiting messages onto the ring one at a time, serving the queues in turn. It stamps each outgoing message with the index of the queue it came from, so a host process cannot claim to be any other endpoint. That stamped originator therefore works as a capability. The top bit of the index separates kernel endpoints from user endpoints.

Every message sent downstream is a request. Each request reserves one slot in the upstream queue of the same endpoint, and the fixed-size response later fills that slot, so the bridge never drops a response. A message from the ring that is not a response uses only the unreserved space in its queue. When no such space is free, the bridge discards it and counts the loss for that endpoint. Both queue sets are stored as per-queue head and tail pointers over one shared buffer per direction.

Top module: `qpb_bridge`

## Requirements
- R1: A doorbell to an active queue that is not full appends its destination and payload to that downstream queue. Messages from one queue reach the ring in the order they were written.
- R2: The originator field of every ring message equals the index of the downstream queue it was taken from. The host has no way to supply that field.
- R3: `ring_tx_kernel` is 1 exactly when the most significant bit of `ring_tx_orig` is 0 (kernel endpoint), and 0 otherwise (user endpoint).
- R4: Among the eligible queues, the grant goes to the first one found after the queue served last, searching upward and wrapping. After reset the search starts at queue 0. Each accepted transfer (`ring_tx_valid` and `ring_tx_ready`) moves exactly one message.
- R5: A ring message that is not a response is written to the upstream queue of `ring_rx_ep` only if stored entries + reserved slots + (1 if a request from that same queue is accepted in this cycle) is less than the upstream depth. Otherwise it is dropped and that endpoint's drop count rises by one, stopping at all ones.
- R6: Each accepted request reserves one upstream slot for its queue. A downstream queue is eligible only when it is non-empty and stored + reserved in its upstream queue is less than the depth.
- R7: A response (`ring_rx_resp`=1) to an endpoint with a reservation is always stored and releases one reservation. A response with no reservation is dropped and counted as in R5.
- R8: A doorbell whose queue index is at or above `active_pairs`, or whose downstream queue already holds its full depth, is ignored. It raises `db_err` for exactly the next cycle.
- R9: `up_avail`, `up_src`, `up_resp` and `up_payload` show the oldest entry of the upstream queue `up_qid`. A pop removes that entry. A pop on an empty queue has no effect.
- R10: After reset all queues are empty, no reservations are held, all drop counts are 0, `ring_tx_valid` is 0 and `db_err` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| active_pairs | input | ID_W+1 | Number of queue pairs in use |
| db_valid | input | 1 | Doorbell write strobe |
| db_qid | input | ID_W | Downstream queue index for the doorbell |
| db_dst | input | RING_ID_W | Ring destination of the new message |
| db_payload | input | DATA_W | Message body |
| db_err | output | 1 | Ignored doorbell in the previous cycle |
| ring_tx_valid | output | 1 | Message offered to the ring |
| ring_tx_ready | input | 1 | Ring accepts the offered message |
| ring_tx_dst | output | RING_ID_W | Destination of the offered message |
| ring_tx_orig | output | ID_W | Stamped originator (queue index) |
| ring_tx_kernel | output | 1 | Originator is a kernel endpoint |
| ring_tx_payload | output | DATA_W | Body of the offered message |
| ring_rx_valid | input | 1 | Ring message for a host endpoint |
| ring_rx_ep | input | ID_W | Target endpoint |
| ring_rx_src | input | RING_ID_W | Ring node that sent it |
| ring_rx_resp | input | 1 | Message is a fixed-size response |
| ring_rx_payload | input | DATA_W | Message body |
| up_pop | input | 1 | Remove head of upstream queue `up_qid` |
| up_qid | input | ID_W | Upstream queue being read |
| up_avail | output | 1 | Selected upstream queue is non-empty |
| up_src | output | RING_ID_W | Sender of head entry |
| up_resp | output | 1 | Head entry is a response |
| up_payload | output | DATA_W | Body of head entry |
| drop_qid | input | ID_W | Endpoint whose drop count is shown |
| drop_count | output | DROP_W | Messages dropped for `drop_qid` |

## Verification
A wrong pointer or occupancy count shows up at the ports on the next accepted transfer or pop. The payload or order seen there then differs from what was written. A lost or extra reservation changes which queues are eligible, so the round-robin grant sequence diverges within a few requests. It also makes a response drop or lets a non-response into space that should be held, and that shows up in `drop_count` in the same cycle as the update. The bench runs a behavioural model next to the design and compares every output on every clock. A divergence is therefore reported in the cycle where it first reaches a port.

// File: rtl/qpb_pkg.sv
package qpb_pkg;
   // Upper bound on endpoint queue pairs the bridge can serve.
   localparam int unsigned QPB_MAX_PAIRS = 1024;

   // Width of a per-queue index for a given number of queues.
   function automatic int unsigned qpb_idx_w(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/qpb_qbank.sv
// A bank of FIFO queues sharing one storage array; each queue owns a
// fixed slice addressed by {queue, pointer}.
module qpb_qbank import qpb_pkg::*; #(
   parameter int unsigned NQ    = 8,
   parameter int unsigned DEPTH = 4,
   parameter int unsigned W     = 32,
   localparam int unsigned QW   = qpb_idx_w(NQ),
   localparam int unsigned PW   = $clog2(DEPTH),
   localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_en,
   input  logic [QW-1:0]          wr_q,
   input  logic [W-1:0]           wr_data,
   input  logic                   rd_en,
   input  logic [QW-1:0]          rd_q,
   output logic [W-1:0]           rd_data,
   output logic [NQ-1:0][CW-1:0]  occ
);
   localparam int unsigned SLOTS = NQ * DEPTH;

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("qpb_qbank: DEPTH must be a power of two of at least 2");
   end

   logic [W-1:0]          mem [SLOTS];
   logic [NQ-1:0][PW-1:0] heads;
   logic [NQ-1:0][PW-1:0] tails;
   logic [QW+PW-1:0]      wr_idx;
   logic [QW+PW-1:0]      rd_idx;

   assign wr_idx  = {wr_q, tails[wr_q]};
   assign rd_idx  = {rd_q, heads[rd_q]};
   assign rd_data = mem[rd_idx];

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_idx] <= wr_data;
   end

   for (genvar q = 0; q < NQ; q++) begin : g_q
      logic [PW-1:0] hd;
      logic [PW-1:0] tl;
      logic [CW-1:0] oc;
      logic          we;
      logic          re;

      assign we = wr_en && (wr_q == QW'(q));
      assign re = rd_en && (rd_q == QW'(q));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            hd <= '0;
            tl <= '0;
            oc <= '0;
         end else begin
            if (we) tl <= tl + 1'b1;
            if (re) hd <= hd + 1'b1;
            oc <= oc + CW'(we) - CW'(re);
         end
      end

      assign heads[q] = hd;
      assign tails[q] = tl;
      assign occ[q]   = oc;
   end

   // The controller above must never write a full queue (R5, R1).
   assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (occ[wr_q] != CW'(DEPTH)));

   // Reads only happen on a queue that holds data (R9, R1).
   assert_no_underflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |-> (occ[rd_q] != '0));
endmodule

// File: rtl/qpb_rr_arb.sv
// Round-robin arbiter: searches upward from the queue after the one last
// served and wraps; the pointer moves only when a grant is accepted.
module qpb_rr_arb import qpb_pkg::*; #(
   parameter int unsigned N  = 8,
   localparam int unsigned QW = qpb_idx_w(N)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [N-1:0]  req,
   input  logic          adv,
   output logic          gnt_any,
   output logic [QW-1:0] gnt_idx
);
   logic [QW-1:0] last_q;

   always_comb begin : p_search
      gnt_any = 1'b0;
      gnt_idx = '0;
      for (int k = 1; k <= int'(N); k++) begin
         int c;
         c = (int'(last_q) + k) % int'(N);
         if (!gnt_any && req[c]) begin
            gnt_any = 1'b1;
            gnt_idx = QW'(c);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)   last_q <= QW'(N - 1);
      else if (adv) last_q <= gnt_idx;
   end

   // A grant always names a requesting queue (R4).
   assert_grant_is_request_R4: assert property (@(posedge clk) disable iff (!rst_n)
      gnt_any |-> req[gnt_idx]);

   // The pointer only advances on a real grant (R4).
   assert_advance_needs_grant_R4: assert property (@(posedge clk) disable iff (!rst_n)
      adv |-> gnt_any);
endmodule

// File: rtl/qpb_bridge.sv
module qpb_bridge import qpb_pkg::*; #(
   parameter int unsigned NUM_QP    = 8,
   parameter int unsigned ID_W      = 3,
   parameter int unsigned RING_ID_W = 4,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned DQ_DEPTH  = 4,
   parameter int unsigned UQ_DEPTH  = 4,
   parameter int unsigned DROP_W    = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [ID_W:0]        active_pairs,
   input  logic                 db_valid,
   input  logic [ID_W-1:0]      db_qid,
   input  logic [RING_ID_W-1:0] db_dst,
   input  logic [DATA_W-1:0]    db_payload,
   output logic                 db_err,
   output logic                 ring_tx_valid,
   input  logic                 ring_tx_ready,
   output logic [RING_ID_W-1:0] ring_tx_dst,
   output logic [ID_W-1:0]      ring_tx_orig,
   output logic                 ring_tx_kernel,
   output logic [DATA_W-1:0]    ring_tx_payload,
   input  logic                 ring_rx_valid,
   input  logic [ID_W-1:0]      ring_rx_ep,
   input  logic [RING_ID_W-1:0] ring_rx_src,
   input  logic                 ring_rx_resp,
   input  logic [DATA_W-1:0]    ring_rx_payload,
   input  logic                 up_pop,
   input  logic [ID_W-1:0]      up_qid,
   output logic                 up_avail,
   output logic [RING_ID_W-1:0] up_src,
   output logic                 up_resp,
   output logic [DATA_W-1:0]    up_payload,
   input  logic [ID_W-1:0]      drop_qid,
   output logic [DROP_W-1:0]    drop_count
);
   localparam int unsigned QW  = qpb_idx_w(NUM_QP);
   localparam int unsigned CWD = $clog2(DQ_DEPTH + 1);
   localparam int unsigned CWU = $clog2(UQ_DEPTH + 1);
   localparam int unsigned SW  = CWU + 2;
   localparam int unsigned DW  = RING_ID_W + DATA_W;
   localparam int unsigned UW  = RING_ID_W + 1 + DATA_W;

   // ---------------- elaboration checks ----------------
   if (NUM_QP < 2 || NUM_QP > QPB_MAX_PAIRS) begin : g_bad_pairs
      $error("qpb_bridge: NUM_QP must lie in 2..QPB_MAX_PAIRS");
   end
   if (NUM_QP > (1 << ID_W) || QW > ID_W) begin : g_bad_idw
      $error("qpb_bridge: ID_W too narrow for NUM_QP");
   end
   if (DROP_W < 1) begin : g_bad_drop
      $error("qpb_bridge: DROP_W must be positive");
   end

   // ---------------- doorbell side ----------------
   logic [NUM_QP-1:0][CWD-1:0] d_occ;
   logic [QW-1:0]              db_q;
   logic                       db_in_range;
   logic                       db_full;
   logic                       d_wr;
   logic                       db_err_q;

   assign db_q        = db_qid[QW-1:0];
   assign db_in_range = ({1'b0, db_qid} < active_pairs) && (32'(db_qid) < NUM_QP);
   assign db_full     = db_in_range && (d_occ[db_q] == CWD'(DQ_DEPTH));
   assign d_wr        = db_valid && db_in_range && !db_full;

   always_ff @(posedge clk) begin
      if (!rst_n) db_err_q <= 1'b0;
      else        db_err_q <= db_valid && !(db_in_range && !db_full);
   end
   assign db_err = db_err_q;

   // ---------------- arbitration and ring transmit ----------------
   logic [NUM_QP-1:0]          elig;
   logic                       gnt_any;
   logic [QW-1:0]              gnt_idx;
   logic                       tx_fire;
   logic [DW-1:0]              d_head;
   logic [NUM_QP-1:0][CWU-1:0] u_occ;
   logic [NUM_QP-1:0][CWU-1:0] res;

   qpb_rr_arb #(.N(NUM_QP)) u_arb (
      .clk     (clk),
      .rst_n   (rst_n),
      .req     (elig),
      .adv     (tx_fire),
      .gnt_any (gnt_any),
      .gnt_idx (gnt_idx)
   );

   qpb_qbank #(.NQ(NUM_QP), .DEPTH(DQ_DEPTH), .W(DW)) u_down (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (d_wr),
      .wr_q    (db_q),
      .wr_data ({db_dst, db_payload}),
      .rd_en   (tx_fire),
      .rd_q    (gnt_idx),
      .rd_data (d_head),
      .occ     (d_occ)
   );

   assign ring_tx_valid   = gnt_any;
   assign tx_fire         = gnt_any && ring_tx_ready;
   assign ring_tx_dst     = d_head[DW-1 -: RING_ID_W];
   assign ring_tx_payload = d_head[DATA_W-1:0];
   assign ring_tx_orig    = ID_W'(gnt_idx);
   assign ring_tx_kernel  = ~ring_tx_orig[ID_W-1];

   // ---------------- ring receive, reservations, drops ----------------
   logic                        rx_in_range;
   logic [QW-1:0]               rx_q;
   logic [NUM_QP-1:0]           acc;
   logic                        rx_ok;
   logic [NUM_QP-1:0][DROP_W-1:0] drops;

   assign rx_in_range = 32'(ring_rx_ep) < NUM_QP;
   assign rx_q        = ring_rx_ep[QW-1:0];

   for (genvar q = 0; q < NUM_QP; q++) begin : g_ep
      logic              inj;
      logic              hit;
      logic              fits;
      logic              take;
      logic              lost;
      logic [CWU-1:0]    rs;
      logic [DROP_W-1:0] dc;

      assign inj  = tx_fire && (gnt_idx == QW'(q));
      assign hit  = ring_rx_valid && rx_in_range && (rx_q == QW'(q));
      assign fits = (SW'(u_occ[q]) + SW'(rs) + SW'(inj)) < SW'(UQ_DEPTH);
      assign acc[q] = hit && (ring_rx_resp ? (rs != '0) : fits);
      assign take = acc[q] && ring_rx_resp;
      assign lost = hit && !acc[q];

      assign elig[q] = (d_occ[q] != '0) &&
                       ((SW'(u_occ[q]) + SW'(rs)) < SW'(UQ_DEPTH));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            rs <= '0;
            dc <= '0;
         end else begin
            rs <= rs + CWU'(inj) - CWU'(take);
            if (lost && (dc != {DROP_W{1'b1}})) dc <= dc + 1'b1;
         end
      end

      assign res[q]   = rs;
      assign drops[q] = dc;

      // Stored plus reserved entries never exceed the upstream depth (R6, R7).
      assert_reserve_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (SW'(u_occ[q]) + SW'(res[q])) <= SW'(UQ_DEPTH));
   end

   assign rx_ok = |acc;

   // ---------------- upstream queues and host pop ----------------
   logic [QW-1:0] up_q;
   logic          up_in_range;
   logic [UW-1:0] u_head;

   assign up_q        = up_qid[QW-1:0];
   assign up_in_range = 32'(up_qid) < NUM_QP;
   assign up_avail    = up_in_range && (u_occ[up_q] != '0);

   qpb_qbank #(.NQ(NUM_QP), .DEPTH(UQ_DEPTH), .W(UW)) u_up (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (rx_ok),
      .wr_q    (rx_q),
      .wr_data ({ring_rx_src, ring_rx_resp, ring_rx_payload}),
      .rd_en   (up_pop && up_avail),
      .rd_q    (up_q),
      .rd_data (u_head),
      .occ     (u_occ)
   );

   assign up_src     = u_head[UW-1 -: RING_ID_W];
   assign up_resp    = u_head[DATA_W];
   assign up_payload = u_head[DATA_W-1:0];

   assign drop_count = (32'(drop_qid) < NUM_QP) ? drops[drop_qid[QW-1:0]] : '0;

   // An offered message always comes from a queue holding data (R1).
   assert_tx_has_data_R1: assert property (@(posedge clk) disable iff (!rst_n)
      ring_tx_valid |-> (d_occ[gnt_idx] != '0));

   // An error pulse only follows a doorbell (R8).
   assert_err_after_doorbell_R8: assert property (@(posedge clk) disable iff (!rst_n)
      db_err |-> $past(db_valid));
endmodule

// File: tb/qpb_bridge_tb.sv
module qpb_bridge_tb;
   localparam int NQ  = 8;
   localparam int IDW = 3;
   localparam int RW  = 4;
   localparam int DQ  = 4;
   localparam int UQ  = 4;
   localparam int ACT = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic [IDW:0]    active_pairs = (IDW+1)'(ACT);
   logic            db_valid = 0;
   logic [IDW-1:0]  db_qid = 0;
   logic [RW-1:0]   db_dst = 0;
   logic [31:0]     db_payload = 0;
   logic            db_err;
   logic            ring_tx_valid;
   logic            ring_tx_ready = 0;
   logic [RW-1:0]   ring_tx_dst;
   logic [IDW-1:0]  ring_tx_orig;
   logic            ring_tx_kernel;
   logic [31:0]     ring_tx_payload;
   logic            ring_rx_valid = 0;
   logic [IDW-1:0]  ring_rx_ep = 0;
   logic [RW-1:0]   ring_rx_src = 0;
   logic            ring_rx_resp = 0;
   logic [31:0]     ring_rx_payload = 0;
   logic            up_pop = 0;
   logic [IDW-1:0]  up_qid = 0;
   logic            up_avail;
   logic [RW-1:0]   up_src;
   logic            up_resp;
   logic [31:0]     up_payload;
   logic [IDW-1:0]  drop_qid = 0;
   logic [7:0]      drop_count;

   qpb_bridge u_dut (
      .clk(clk), .rst_n(rst_n), .active_pairs(active_pairs),
      .db_valid(db_valid), .db_qid(db_qid), .db_dst(db_dst), .db_payload(db_payload),
      .db_err(db_err),
      .ring_tx_valid(ring_tx_valid), .ring_tx_ready(ring_tx_ready), .ring_tx_dst(ring_tx_dst),
      .ring_tx_orig(ring_tx_orig), .ring_tx_kernel(ring_tx_kernel), .ring_tx_payload(ring_tx_payload),
      .ring_rx_valid(ring_rx_valid), .ring_rx_ep(ring_rx_ep), .ring_rx_src(ring_rx_src),
      .ring_rx_resp(ring_rx_resp), .ring_rx_payload(ring_rx_payload),
      .up_pop(up_pop), .up_qid(up_qid), .up_avail(up_avail), .up_src(up_src),
      .up_resp(up_resp), .up_payload(up_payload),
      .drop_qid(drop_qid), .drop_count(drop_count)
   );

   // ---------------- reference model state ----------------
   int          dcnt [NQ];
   int          dm_dst [NQ][DQ];
   logic [31:0] dm_pl [NQ][DQ];
   int          ucnt [NQ];
   int          um_src [NQ][UQ];
   int          um_rsp [NQ][UQ];
   logic [31:0] um_pl [NQ][UQ];
   int          ures [NQ];
   int          drops [NQ];
   int          rr_last;
   bit          err_exp;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 0;

   task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // One clock: compare outputs with the model, then advance the model.
   task automatic step();
      bit any, fire, bad, inj, acc, av, popdo;
      int g, pq, ep;
      #3;
      any = 0; g = 0;
      for (int k = 1; k <= NQ; k++) begin
         int c;
         c = (rr_last + k) % NQ;
         if (!any && dcnt[c] > 0 && (ucnt[c] + ures[c]) < UQ) begin
            any = 1; g = c;
         end
      end
      chk("R6 tx_valid", 64'(ring_tx_valid), 64'(any));
      if (any) begin
         chk("R1 tx_dst",     64'(ring_tx_dst),     64'(dm_dst[g][0]));
         chk("R1 tx_payload", 64'(ring_tx_payload), 64'(dm_pl[g][0]));
         chk("R2 R4 tx_orig", 64'(ring_tx_orig),    64'(g));
         chk("R3 tx_kernel",  64'(ring_tx_kernel),  64'(g < (1 << (IDW-1))));
      end
      pq = int'(up_qid);
      av = ucnt[pq] > 0;
      chk("R9 up_avail", 64'(up_avail), 64'(av));
      if (av) begin
         chk("R9 up_src",         64'(up_src),     64'(um_src[pq][0]));
         chk("R7 R9 up_resp",     64'(up_resp),    64'(um_rsp[pq][0]));
         chk("R9 up_payload",     64'(up_payload), 64'(um_pl[pq][0]));
      end
      chk("R5 drop_count", 64'(drop_count), 64'(drops[int'(drop_qid)]));
      chk("R8 db_err",     64'(db_err),     64'(err_exp));

      fire  = any && ring_tx_ready;
      bad   = db_valid && (int'(db_qid) >= ACT || dcnt[int'(db_qid)] == DQ);
      ep    = int'(ring_rx_ep);
      inj   = fire && (g == ep);
      acc   = ring_rx_resp ? (ures[ep] > 0) : ((ucnt[ep] + ures[ep] + int'(inj)) < UQ);
      popdo = up_pop && av;

      @(posedge clk);
      err_exp = bad;
      if (fire) begin
         for (int i = 0; i < DQ-1; i++) begin
            dm_dst[g][i] = dm_dst[g][i+1];
            dm_pl[g][i]  = dm_pl[g][i+1];
         end
         dcnt[g]--;
         ures[g]++;
         rr_last = g;
      end
      if (db_valid && !bad) begin
         dm_dst[int'(db_qid)][dcnt[int'(db_qid)]] = int'(db_dst);
         dm_pl[int'(db_qid)][dcnt[int'(db_qid)]]  = db_payload;
         dcnt[int'(db_qid)]++;
      end
      if (popdo) begin
         for (int i = 0; i < UQ-1; i++) begin
            um_src[pq][i] = um_src[pq][i+1];
            um_rsp[pq][i] = um_rsp[pq][i+1];
            um_pl[pq][i]  = um_pl[pq][i+1];
         end
         ucnt[pq]--;
      end
      if (ring_rx_valid) begin
         if (acc) begin
            um_src[ep][ucnt[ep]] = int'(ring_rx_src);
            um_rsp[ep][ucnt[ep]] = int'(ring_rx_resp);
            um_pl[ep][ucnt[ep]]  = ring_rx_payload;
            ucnt[ep]++;
            if (ring_rx_resp) ures[ep]--;
         end else if (drops[ep] < 255) begin
            drops[ep]++;
         end
      end
      @(negedge clk);
   endtask

   task automatic cyc();
      step();
      db_valid = 0; ring_rx_valid = 0; up_pop = 0;
   endtask

   task automatic bell(int q, int dst, logic [31:0] pl);
      db_valid = 1; db_qid = IDW'(q); db_dst = RW'(dst); db_payload = pl;
      cyc();
   endtask

   task automatic rx(int ep, int src, bit rsp, logic [31:0] pl);
      ring_rx_valid = 1; ring_rx_ep = IDW'(ep); ring_rx_src = RW'(src);
      ring_rx_resp = rsp; ring_rx_payload = pl;
      cyc();
   endtask

   task automatic pop(int q);
      up_pop = 1; up_qid = IDW'(q);
      cyc();
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) cyc();
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog expired actual=hung expected=done");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin : main
      for (int q = 0; q < NQ; q++) begin
         dcnt[q] = 0; ucnt[q] = 0; ures[q] = 0; drops[q] = 0;
      end
      rr_last = NQ - 1;
      err_exp = 0;

      // R10: reset state seen while reset is held
      repeat (3) @(negedge clk);
      #3;
      chk("R10 tx_valid in reset", 64'(ring_tx_valid), 64'd0);
      chk("R10 db_err in reset",   64'(db_err),        64'd0);
      chk("R10 up_avail in reset", 64'(up_avail),      64'd0);
      chk("R10 drop in reset",     64'(drop_count),    64'd0);
      @(negedge clk);
      rst_n = 1;
      idle(2);

      // R1 R2 R3 R4: ring stalled, several queues filled, then drained
      ring_tx_ready = 0;
      bell(0, 1, 32'hA000_0001);
      bell(0, 2, 32'hA000_0002);
      bell(3, 3, 32'hA000_0003);
      bell(5, 4, 32'hA000_0004);
      bell(4, 5, 32'hA000_0005);
      idle(2);
      ring_tx_ready = 1;
      idle(8);

      // R8: out-of-range doorbells and a full downstream queue
      bell(6, 1, 32'hBAD0_0006);
      bell(7, 1, 32'hBAD0_0007);
      ring_tx_ready = 0;
      for (int i = 0; i < 5; i++) bell(1, i, 32'hB100_0000 + i);
      idle(1);
      ring_tx_ready = 1;
      idle(6);

      // R5 R7: fill upstream 2 with non-responses, then overflow
      drop_qid = 2;
      for (int i = 0; i < 5; i++) rx(2, 9, 0, 32'hC200_0000 + i);
      rx(2, 9, 1, 32'hC2FF_0000);      // response with no reservation: dropped
      // R6: queue 2 has no free upstream slot, so it is not eligible
      bell(2, 6, 32'hD200_0001);
      idle(3);
      pop(2);
      pop(2);                           // now eligible, request reserves a slot
      idle(2);
      rx(2, 9, 0, 32'hC200_0010);       // fits
      rx(2, 9, 0, 32'hC200_0011);       // only the reserved slot left: dropped
      rx(2, 9, 1, 32'hC2AA_0001);       // response always stored
      for (int i = 0; i < 5; i++) pop(2);

      // Mixed random traffic
      for (int i = 0; i < 4000; i++) begin
         ring_tx_ready = 1'($urandom_range(0, 3) != 0);
         drop_qid = IDW'($urandom_range(0, NQ-1));
         if ($urandom_range(0, 2) == 0) begin
            db_valid = 1; db_qid = IDW'($urandom_range(0, NQ-1));
            db_dst = RW'($urandom); db_payload = $urandom;
         end
         if ($urandom_range(0, 2) == 0) begin
            ring_rx_valid = 1; ring_rx_ep = IDW'($urandom_range(0, NQ-1));
            ring_rx_src = RW'($urandom); ring_rx_resp = 1'($urandom_range(0, 2) != 0);
            ring_rx_payload = $urandom;
         end
         if ($urandom_range(0, 1) == 0) begin
            up_pop = 1; up_qid = IDW'($urandom_range(0, NQ-1));
         end else begin
            up_qid = IDW'($urandom_range(0, NQ-1));
         end
         cyc();
      end

      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule